// File: doc/BRIEF.md
# Cascaded Median Impulse-Noise Filter

This block cleans isolated full-bright and full-dark specks out of a streaming video luminance channel. Pixels arrive in raster order, one per cycle when the valid strobe is high, in frames of `LINE_W` pixels by `FRAME_H` lines. The first valid pixel after reset is the top-left pixel of a frame. A chain of `N_STAGES` identical filter stages sits in series. Each stage keeps the two previous lines in on-chip row memories and assembles a 3x3 neighbourhood around a centre pixel. It then writes out the median of those nine luma values in place of the centre pixel.

One enable bit per stage decides whether that stage filters or simply forwards its centre pixel. A forwarding stage keeps exactly the same cycle and sample delay as a filtering one, so the enable word can change at any time without shifting luma against chroma. The single chroma channel (interleaved Cb/Cr) is never filtered, only delayed in step with luma. For bring-up, a deterministic pattern generator at the input can force chosen pixels to full scale or to zero.

Top module: `snpf_top`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0, and `out_y` and `out_c` are 0.
- R2: An enabled stage replaces each interior centre luma value with the median (5th smallest) of the nine luma values at rows above, same and below and at columns left, same and right of that centre.
- R3: Each stage's output sample lags its input sample by `LINE_W+1` valid samples, so the whole chain lags by `N_STAGES*(LINE_W+1)` valid samples. Frame positions count from the first valid pixel after reset and wrap every `LINE_W*FRAME_H` samples.
- R4: Centre pixels in column 0, column `LINE_W-1`, row 0 or row `FRAME_H-1` leave an enabled stage unchanged.
- R5: Stages run in series. Bit i of `stage_en` controls stage i, and bit 0 is the stage nearest the input.
- R6: A stage whose enable bit is 0 forwards its centre luma unchanged with the same cycle and sample delay as a filtering stage.
- R7: `out_c` is the unaltered chroma sample of the same frame position as `out_y`.
- R8: `out_valid` equals `in_valid` delayed by exactly `4*N_STAGES` clock cycles. Output data changes only with `out_valid` high, and gaps in `in_valid` do not alter any result.
- R9: A 16-bit shift register seeded with 0xACE1 shifts left on every valid input, taking in bit15^bit13^bit12^bit10 at bit 0. With `noise_en` high, the input luma becomes all ones when its low nibble before the shift is 0xF, and zero when that nibble is 0x0. With `noise_en` low, the luma passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel strobe |
| in_y | input | W | Input luma |
| in_c | input | W | Input chroma (interleaved Cb/Cr) |
| noise_en | input | 1 | Enables the test impulse-noise generator |
| stage_en | input | N_STAGES | Per-stage filter enable, bit 0 first in the chain |
| out_valid | output | 1 | Output pixel strobe |
| out_y | output | W | Filtered luma |
| out_c | output | W | Delay-matched chroma |

## Verification
The bench builds the block with 8-pixel lines, 5-line frames and three stages. This makes every row and column border, the frame wrap and the whole cascade appear within a few hundred cycles while keeping all three stage-delay offsets in play. Enable words with holes (such as 101 and 010) show that a bypassed middle or outer stage keeps the alignment. Gapped valid patterns combined with the noise generator show that the shift register and the line memories advance only on valid samples.

// File: rtl/snpf_pkg.sv
package snpf_pkg;
   // pipeline registers in one stage: window, row sort, candidates, output
   localparam int STAGE_LAT = 4;
   localparam logic [15:0] NOISE_SEED = 16'hACE1;

   function automatic logic [15:0] noise_step(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction
endpackage

// File: rtl/snpf_noise.sv
module snpf_noise #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         enable,
   input  logic [W-1:0] in_y,
   output logic [W-1:0] out_y
);
   import snpf_pkg::*;

   logic [15:0] state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        state <= NOISE_SEED;
      else if (in_valid) state <= noise_step(state);
   end

   always_comb begin
      out_y = in_y;
      if (enable && state[3:0] == 4'hF) out_y = '1;
      if (enable && state[3:0] == 4'h0) out_y = '0;
   end
endmodule

// File: rtl/snpf_stage.sv
module snpf_stage #(
   parameter int W       = 8,
   parameter int LINE_W  = 640,
   parameter int FRAME_H = 480,
   parameter int IDX     = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         in_valid,
   input  logic [W-1:0] in_y,
   input  logic [W-1:0] in_c,
   output logic         out_valid,
   output logic [W-1:0] out_y,
   output logic [W-1:0] out_c
);
   localparam int CW    = $clog2(LINE_W);
   localparam int RW    = $clog2(FRAME_H);
   localparam int TOTAL = LINE_W * FRAME_H;
   localparam int OFF   = (IDX * (LINE_W + 1)) % TOTAL;
   localparam int START = (TOTAL - OFF) % TOTAL;
   localparam int COL0  = START % LINE_W;
   localparam int ROW0  = START / LINE_W;

   function automatic logic [W-1:0] mx(input logic [W-1:0] a, input logic [W-1:0] b);
      return (a > b) ? a : b;
   endfunction
   function automatic logic [W-1:0] mn(input logic [W-1:0] a, input logic [W-1:0] b);
      return (a < b) ? a : b;
   endfunction
   function automatic logic [W-1:0] md(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic [W-1:0] c);
      return mx(mn(a, b), mn(mx(a, b), c));
   endfunction

   // row memories: previous line carries chroma, line before carries luma only
   logic [2*W-1:0] mem_mid [LINE_W];
   logic [W-1:0]   mem_top [LINE_W];
   logic [CW-1:0]  col;
   logic [RW-1:0]  row;
   logic [2*W-1:0] mid_rd;
   logic [W-1:0]   top_rd;
   int             cc_i, cr_i;
   logic           edge_c;

   assign mid_rd = mem_mid[col];
   assign top_rd = mem_top[col];

   always_ff @(posedge clk) begin
      if (in_valid) begin
         mem_mid[col] <= {in_c, in_y};
         mem_top[col] <= mid_rd[W-1:0];
      end
   end

   // frame position of the centre formed by this sample: one line and one pixel back
   always_comb begin
      cc_i = (col == '0) ? LINE_W - 1 : int'(col) - 1;
      cr_i = int'(row) - 1 - ((col == '0) ? 1 : 0);
      if (cr_i < 0) cr_i = cr_i + FRAME_H;
      edge_c = (cc_i == 0) || (cc_i == LINE_W - 1) || (cr_i == 0) || (cr_i == FRAME_H - 1);
   end

   // window: rows 0 top,1 mid,2 bottom; columns 0 oldest,2 newest
   logic [W-1:0] win [3][3];
   logic [W-1:0] mc1, mc2;
   logic         v0, bord0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col   <= CW'(COL0);
         row   <= RW'(ROW0);
         v0    <= 1'b0;
         bord0 <= 1'b0;
         mc1   <= '0;
         mc2   <= '0;
         for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) win[r][c] <= '0;
      end else begin
         v0 <= in_valid;
         if (in_valid) begin
            if (col == CW'(LINE_W - 1)) begin
               col <= '0;
               row <= (row == RW'(FRAME_H - 1)) ? '0 : row + 1'b1;
            end else begin
               col <= col + 1'b1;
            end
            for (int r = 0; r < 3; r++) begin
               win[r][0] <= win[r][1];
               win[r][1] <= win[r][2];
            end
            win[0][2] <= top_rd;
            win[1][2] <= mid_rd[W-1:0];
            win[2][2] <= in_y;
            mc1   <= mc2;
            mc2   <= mid_rd[2*W-1:W];
            bord0 <= edge_c;
         end
      end
   end

   // row sort, then candidate selection, then final median of three
   logic [W-1:0] lo1 [3], mi1 [3], hi1 [3];
   logic [W-1:0] cy1, cc1, cy2, cc2, cl2, cm2, ch2;
   logic         v1, b1, v2, b2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {v1, b1, v2, b2} <= '0;
         {cy1, cc1, cy2, cc2, cl2, cm2, ch2} <= '0;
         for (int r = 0; r < 3; r++) begin
            lo1[r] <= '0;
            mi1[r] <= '0;
            hi1[r] <= '0;
         end
         out_valid <= 1'b0;
         out_y     <= '0;
         out_c     <= '0;
      end else begin
         for (int r = 0; r < 3; r++) begin
            lo1[r] <= mn(mn(win[r][0], win[r][1]), win[r][2]);
            mi1[r] <= md(win[r][0], win[r][1], win[r][2]);
            hi1[r] <= mx(mx(win[r][0], win[r][1]), win[r][2]);
         end
         v1  <= v0;
         b1  <= bord0;
         cy1 <= win[1][1];
         cc1 <= mc1;
         cl2 <= mx(mx(lo1[0], lo1[1]), lo1[2]);
         cm2 <= md(mi1[0], mi1[1], mi1[2]);
         ch2 <= mn(mn(hi1[0], hi1[1]), hi1[2]);
         v2  <= v1;
         b2  <= b1;
         cy2 <= cy1;
         cc2 <= cc1;
         out_valid <= v2;
         if (v2) begin
            out_y <= (en && !b2) ? md(cl2, cm2, ch2) : cy2;
            out_c <= cc2;
         end
      end
   end
endmodule

// File: rtl/snpf_top.sv
module snpf_top #(
   parameter int W        = 8,
   parameter int LINE_W   = 640,
   parameter int FRAME_H  = 480,
   parameter int N_STAGES = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [W-1:0]        in_y,
   input  logic [W-1:0]        in_c,
   input  logic                noise_en,
   input  logic [N_STAGES-1:0] stage_en,
   output logic                out_valid,
   output logic [W-1:0]        out_y,
   output logic [W-1:0]        out_c
);
   if (W < 2)        $error("snpf_top: W must be at least 2");
   if (LINE_W < 3)   $error("snpf_top: LINE_W must be at least 3");
   if (FRAME_H < 3)  $error("snpf_top: FRAME_H must be at least 3");
   if (N_STAGES < 1) $error("snpf_top: N_STAGES must be at least 1");

   logic [W-1:0] inj_y;
   logic         ch_v [N_STAGES+1];
   logic [W-1:0] ch_y [N_STAGES+1];
   logic [W-1:0] ch_c [N_STAGES+1];

   snpf_noise #(.W(W)) u_noise (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .enable(noise_en),
      .in_y(in_y), .out_y(inj_y)
   );

   assign ch_v[0] = in_valid;
   assign ch_y[0] = inj_y;
   assign ch_c[0] = in_c;

   for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
      snpf_stage #(.W(W), .LINE_W(LINE_W), .FRAME_H(FRAME_H), .IDX(i)) u_stage (
         .clk(clk), .rst_n(rst_n), .en(stage_en[i]),
         .in_valid(ch_v[i]), .in_y(ch_y[i]), .in_c(ch_c[i]),
         .out_valid(ch_v[i+1]), .out_y(ch_y[i+1]), .out_c(ch_c[i+1])
      );
   end

   assign out_valid = ch_v[N_STAGES];
   assign out_y     = ch_y[N_STAGES];
   assign out_c     = ch_c[N_STAGES];
endmodule

// File: rtl/snpf_checker.sv
module snpf_checker #(
   parameter int W   = 8,
   parameter int LAT = 20
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic         noise_en,
   input logic [W-1:0] in_y,
   input logic [W-1:0] inj_y,
   input logic         out_valid,
   input logic [W-1:0] out_y,
   input logic [W-1:0] out_c
);
   logic [LAT-1:0] vhist;
   int             since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vhist     <= '0;
         since_rst <= 0;
      end else begin
         vhist <= {vhist[LAT-2:0], in_valid};
         if (since_rst < LAT) since_rst <= since_rst + 1;
      end
   end

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vhist[LAT-1]); // R8
   AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < LAT) |-> !out_valid); // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(out_y) && $stable(out_c))); // R8
   AST_NOISE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !noise_en |-> (inj_y == in_y)); // R9
   AST_NOISE_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_y != in_y) |-> (noise_en && (inj_y == '1 || inj_y == '0))); // R9
endmodule

bind snpf_top snpf_checker #(.W(W), .LAT(4 * N_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .noise_en(noise_en),
   .in_y(in_y), .inj_y(inj_y), .out_valid(out_valid), .out_y(out_y), .out_c(out_c)
);

// File: tb/snpf_top_bench.sv
module snpf_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W     = 8;
   localparam int LW    = 8;
   localparam int FH    = 5;
   localparam int NS    = 3;
   localparam int LAT   = 4 * NS;
   localparam int SHIFT = NS * (LW + 1);
   localparam int TOT   = 3 * LW * FH + SHIFT;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [W-1:0]  in_y = '0, in_c = '0;
   logic          noise_en = 1'b0;
   logic [NS-1:0] stage_en = '0;
   logic          out_valid;
   logic [W-1:0]  out_y, out_c;

   int n_chk = 0, n_fail = 0;
   int ysrc [TOT];
   int csrc [TOT];
   int lvl  [NS+1][TOT];

   always #(CLK_PERIOD/2) clk = ~clk;

   snpf_top #(.W(W), .LINE_W(LW), .FRAME_H(FH), .N_STAGES(NS)) u_snpf_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_y(in_y), .in_c(in_c),
      .noise_en(noise_en), .stage_en(stage_en),
      .out_valid(out_valid), .out_y(out_y), .out_c(out_c)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit on_border(input int j);
      int c = j % LW;
      int r = (j / LW) % FH;
      return (c == 0) || (c == LW - 1) || (r == 0) || (r == FH - 1);
   endfunction

   function automatic int median9(input int s, input int j);
      int v [9];
      int k = 0;
      for (int dr = -1; dr <= 1; dr++)
         for (int dc = -1; dc <= 1; dc++) begin
            int p = j + dr * LW + dc;
            v[k] = (p >= 0 && p < TOT) ? lvl[s][p] : 0;
            k++;
         end
      for (int a = 0; a < 9; a++)
         for (int b = 0; b < 8 - a; b++)
            if (v[b] > v[b+1]) begin
               int t = v[b]; v[b] = v[b+1]; v[b+1] = t;
            end
      return v[4];
   endfunction

   // stimulus and reference levels: lvl[0] = after noise, lvl[s+1] = after stage s
   task automatic build(input int pat, input logic [NS-1:0] en, input bit nen);
      logic [15:0] s = 16'hACE1;
      for (int j = 0; j < TOT; j++) begin
         case (pat)
            0: ysrc[j] = (j * 13 + (j / LW) * 7) % 256;
            1: ysrc[j] = (j % 7 == 3) ? 255 : ((j % 11 == 5) ? 0 : 100 + (j % LW) * 3);
            default: ysrc[j] = (j * 37 + (j >> 2) * 5 + pat * 11) % 256;
         endcase
         csrc[j] = (j * 5 + pat * 17) % 256;
         lvl[0][j] = ysrc[j];
         if (nen && s[3:0] == 4'hF) lvl[0][j] = 255;
         if (nen && s[3:0] == 4'h0) lvl[0][j] = 0;
         s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      end
      for (int st = 0; st < NS; st++)
         for (int j = 0; j < TOT; j++)
            lvl[st+1][j] = (en[st] && !on_border(j)) ? median9(st, j) : lvl[st][j];
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run(input int pat, input logic [NS-1:0] en, input bit nen, input bit gapped);
      int hist [$];
      int sent = 0, m = 0, last = 0;
      build(pat, en, nen);
      stage_en = en;
      noise_en = nen;
      do_reset();
      for (int cyc = 0; cyc < 4000; cyc++) begin
         int ev;
         @(negedge clk);
         ev = (cyc >= LAT) ? hist[cyc - LAT] : 0;
         check(out_valid == ev[0], "R8 out_valid", out_valid, ev);
         if (out_valid) begin
            int idx = m - SHIFT;
            if (idx >= 0 && idx < TOT - SHIFT) begin
               string tg = (en == '0) ? "R6 luma" : (on_border(idx) ? "R4 luma" : "R2 luma");
               check(out_y == lvl[NS][idx], tg, out_y, lvl[NS][idx]);
               check(out_c == csrc[idx], "R7 chroma", out_c, csrc[idx]);
            end
            m++;
         end
         if (sent < TOT && (!gapped || ((cyc * 7 + pat) % 5) != 0)) begin
            in_valid = 1'b1;
            in_y = W'(ysrc[sent]);
            in_c = W'(csrc[sent]);
            sent++;
            last = cyc;
         end else begin
            in_valid = 1'b0;
         end
         hist.push_back(int'(in_valid));
         if (sent == TOT && cyc > last + LAT + 2) break;
      end
      check(m == TOT, "R8 output count", m, TOT);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1: reset state
      check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      check(out_y == '0, "R1 out_y", out_y, 0);
      check(out_c == '0, "R1 out_c", out_c, 0);
      // R2, R3, R5: full cascade on impulses, dense stream
      run(1, 3'b111, 1'b0, 1'b0);
      // R6, R9: all stages forwarding, noise visible at output, gapped
      run(0, 3'b000, 1'b1, 1'b1);
      // R9, R2: single first stage cleaning injected noise
      run(2, 3'b001, 1'b1, 1'b0);
      // R5, R8: outer stages only, gapped valid
      run(3, 3'b101, 1'b0, 1'b1);
      // R5, R6: middle stage only, noise and gaps
      run(1, 3'b010, 1'b1, 1'b1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule